// File: doc/BRIEF.md
# Host Parallel Printer Port Controller

This block is the host side of a parallel printer port. A simple byte bus reaches five registers at fixed offsets: the output/input data latch, a printer status register, a control register and two enhanced-mode offsets. The enhanced-mode offsets start address or data transfers toward an external peripheral. The controller drives the eight data lines and the four control lines, the latter at pin level, so they are active low. It also reports the data direction and raises an interrupt request.

No real printer sits on the far side of the port. The block models a printer's behaviour itself. Raising the strobe bit with the printer selected and initialized hands the latched byte to a sink as a one-cycle pulse and makes the printer busy. Later status reads walk the modelled printer through its acknowledge pulse and back to ready.

Enhanced-mode accesses are allowed only when the control register holds one exact line pattern. Any other access to those offsets is dropped. An allowed access that gets no answer within a parameterised number of cycles sets a sticky timeout flag.

Top module: `pp_host_ctrl`

## Requirements
- R1: After reset, status (offset 1) reads 0xD9, control (offset 2) reads 0x0C, data (offset 0) reads 0x00, `irq` is low and `ctl_line_n` is 4'b0011.
- R2: A write to offset 0 loads the output latch, which drives `pd_out`. A read of offset 0 returns the output latch when control bit 5 is 0. When control bit 5 is 1, the read returns the input latch, which samples `pd_in` every cycle while that bit is 1.
- R3: Control keeps written bits 5..0 and reads bits 7..6 as 0. `pd_dir_in` is control bit 5, and `ctl_line_n[i]` is the inverse of control bit i for i = 0..3.
- R4: A control write whose bit 2 is 0 sets status to 0xD8.
- R5: A control write with bits 2, 3 and 0 all 1 clears status bit 7. If the control bit 0 stored before that write was 0, `byte_stb` pulses for exactly one cycle with `byte_val` equal to the output latch; otherwise there is no pulse.
- R6: A status read returns the value held before the read. It then updates status only when bit 7 is 0 and control bit 0 is 0. In that case, if bit 6 is 1 it is cleared; if bit 6 is 0, bits 6 and 7 are both set.
- R7: `irq` goes high on a status read that clears status bit 6 while control bit 4 is 1. Any other status read lowers it, and so does a control write with bit 4 at 0.
- R8: A write to offset 3 (address) or 4 (data) starts a peripheral cycle only when control & 0x2F equals 0x04. The cycle presents `epp_wr`=1, `epp_is_addr`=1 for offset 3 and 0 for offset 4, and the written byte on `epp_wdata`. Otherwise the write is dropped and `epp_req` stays low.
- R9: A read of offset 3 or 4 starts a peripheral cycle only when control & 0x2F equals 0x24, and returns `epp_rdata` captured with `epp_ack`. Otherwise the read is dropped and returns 0xFF.
- R10: A peripheral cycle that sees no `epp_ack` within TIMEOUT_CYC cycles ends with read data 0xFF and sets status bit 0. That bit stays set through later successful cycles.
- R11: A status write with bit 0 at 1 clears status bit 0. A status write never changes any other status bit.
- R12: `bus_done` pulses one cycle after a register access or a dropped peripheral access. For a started peripheral cycle, `bus_done` pulses in the cycle `epp_req` falls, which is TIMEOUT_CYC+1 cycles after the request on a timeout.
- R13: Writes to offsets 5..7 change nothing, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_done | output | 1 | Access complete pulse |
| bus_rdata | output | 8 | Read data, valid with bus_done |
| pd_out | output | 8 | Output data latch |
| pd_in | input | 8 | Data lines from the port |
| pd_dir_in | output | 1 | Data direction, 1 = input |
| ctl_line_n | output | 4 | Control lines at pin level (active low) |
| byte_stb | output | 1 | Byte handed to printer sink |
| byte_val | output | 8 | Byte value for byte_stb |
| irq | output | 1 | Interrupt request |
| epp_req | output | 1 | Peripheral cycle in progress |
| epp_wr | output | 1 | Peripheral cycle is a write |
| epp_is_addr | output | 1 | Peripheral cycle targets address |
| epp_wdata | output | 8 | Peripheral write byte |
| epp_ack | input | 1 | Peripheral completes the cycle |
| epp_rdata | input | 8 | Peripheral read byte |

## Verification
The printer handshake is driven with strobe raised from a low stored value and then raised again from a high one. This separates the first edge, which emits a byte, from the repeat, which must not. Status reads are repeated with strobe high and with strobe low, so the held state and the acknowledge walk are both seen, with interrupt enable both set and cleared. The peripheral offsets are accessed under a wrong line pattern, under the write pattern with the interrupt bit also set (outside the mask), under the read pattern, and with a silent peripheral. These cases separate dropped, started and timed-out cycles.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] ofs_t;

    // register offsets (decoded by software, so fixed)
    localparam ofs_t OFS_DATA     = 3'd0;
    localparam ofs_t OFS_STAT     = 3'd1;
    localparam ofs_t OFS_CTRL     = 3'd2;
    localparam ofs_t OFS_EPP_ADDR = 3'd3;
    localparam ofs_t OFS_EPP_DATA = 3'd4;

    // status byte, bit 7 down to bit 0
    typedef struct packed {
        logic       nbusy;   // 1 = printer ready
        logic       ack;
        logic       paper;
        logic       online;
        logic       nerr;
        logic [1:0] zero;
        logic       tmo;     // sticky peripheral timeout
    } stat_t;

    // control byte, bit 7 down to bit 0
    typedef struct packed {
        logic [1:0] zero;
        logic       dir_in;
        logic       irq_en;
        logic       sel;
        logic       init;
        logic       alf;
        logic       stb;
    } ctrl_t;

    localparam byte_t STAT_RESET  = 8'hD9;
    localparam byte_t STAT_INIT   = 8'hD8;
    localparam byte_t CTRL_RESET  = 8'h0C;
    localparam byte_t CTRL_KEEP   = 8'h3F;
    localparam byte_t EPP_MASK    = 8'h2F;
    localparam byte_t EPP_WR_PAT  = 8'h04;
    localparam byte_t EPP_RD_PAT  = 8'h24;
    localparam byte_t EPP_IDLE_RD = 8'hFF;

    typedef enum logic {ENG_IDLE, ENG_WAIT} eng_state_e;

    function automatic logic is_epp_ofs(input ofs_t a);
        return (a == OFS_EPP_ADDR) || (a == OFS_EPP_DATA);
    endfunction

    function automatic logic epp_allowed(input ctrl_t c, input logic is_read);
        return (byte_t'(c) & EPP_MASK) == (is_read ? EPP_RD_PAT : EPP_WR_PAT);
    endfunction

    function automatic ctrl_t to_ctrl(input byte_t v);
        return ctrl_t'(v & CTRL_KEEP);
    endfunction

endpackage

// File: rtl/pp_ctrl_regs.sv
module pp_ctrl_regs
    import pp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  data_we,
    input  logic  ctrl_we,
    input  byte_t wdata,
    input  byte_t pd_in,
    output ctrl_t ctrl_q,
    output byte_t dout_q,
    output byte_t din_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= to_ctrl(CTRL_RESET);
            dout_q <= '0;
            din_q  <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl_q <= to_ctrl(wdata);
            end
            if (data_we) begin
                dout_q <= wdata;
            end
            if (ctrl_q.dir_in) begin
                din_q <= pd_in;
            end
        end
    end

endmodule

// File: rtl/pp_printer_model.sv
module pp_printer_model
    import pp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ctrl_we,
    input  logic  stat_we,
    input  logic  stat_re,
    input  logic  tmo_set,
    input  byte_t wdata,
    input  ctrl_t ctrl_q,
    input  byte_t dout_q,
    output stat_t stat_q,
    output logic  irq_q,
    output logic  byte_stb_q,
    output byte_t byte_val_q
);

    ctrl_t new_ctrl;
    logic  hs_ready;
    logic  ack_drop;

    assign new_ctrl = to_ctrl(wdata);
    // printer answers reads only while busy with strobe released
    assign hs_ready = !stat_q.nbusy && !ctrl_q.stb;
    assign ack_drop = stat_re && hs_ready && stat_q.ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q     <= stat_t'(STAT_RESET);
            irq_q      <= 1'b0;
            byte_stb_q <= 1'b0;
            byte_val_q <= '0;
        end else begin
            byte_stb_q <= 1'b0;

            if (ctrl_we) begin
                if (!new_ctrl.init) begin
                    stat_q <= stat_t'(STAT_INIT);
                end else if (new_ctrl.sel && new_ctrl.stb) begin
                    stat_q.nbusy <= 1'b0;
                    if (!ctrl_q.stb) begin
                        byte_stb_q <= 1'b1;
                        byte_val_q <= dout_q;
                    end
                end
                if (!new_ctrl.irq_en) begin
                    irq_q <= 1'b0;
                end
            end

            if (stat_we && wdata[0]) begin
                stat_q.tmo <= 1'b0;
            end

            if (tmo_set) begin
                stat_q.tmo <= 1'b1;
            end

            if (stat_re) begin
                if (hs_ready) begin
                    if (stat_q.ack) begin
                        stat_q.ack <= 1'b0;
                    end else begin
                        stat_q.ack   <= 1'b1;
                        stat_q.nbusy <= 1'b1;
                    end
                end
                irq_q <= ack_drop && ctrl_q.irq_en;
            end
        end
    end

endmodule

// File: rtl/pp_epp_engine.sv
module pp_epp_engine
    import pp_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16,
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  start_wr,
    input  logic  start_addr,
    input  byte_t start_wdata,
    input  logic  epp_ack,
    input  byte_t epp_rdata,
    output logic  epp_req,
    output logic  epp_wr,
    output logic  epp_is_addr,
    output byte_t epp_wdata,
    output logic  done_q,
    output byte_t rdata_q,
    output logic  tmo_q
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    eng_state_e       state_q;
    logic [CNT_W-1:0] wait_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ENG_IDLE;
            wait_cnt_q  <= '0;
            epp_req     <= 1'b0;
            epp_wr      <= 1'b0;
            epp_is_addr <= 1'b0;
            epp_wdata   <= '0;
            done_q      <= 1'b0;
            rdata_q     <= '0;
            tmo_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            unique case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        state_q     <= ENG_WAIT;
                        wait_cnt_q  <= '0;
                        epp_req     <= 1'b1;
                        epp_wr      <= start_wr;
                        epp_is_addr <= start_addr;
                        epp_wdata   <= start_wdata;
                    end
                end
                ENG_WAIT: begin
                    if (epp_ack) begin
                        state_q <= ENG_IDLE;
                        epp_req <= 1'b0;
                        done_q  <= 1'b1;
                        rdata_q <= epp_wr ? '0 : epp_rdata;
                    end else if (wait_cnt_q == CNT_LAST) begin
                        state_q <= ENG_IDLE;
                        epp_req <= 1'b0;
                        done_q  <= 1'b1;
                        tmo_q   <= 1'b1;
                        rdata_q <= epp_wr ? '0 : EPP_IDLE_RD;
                    end else begin
                        wait_cnt_q <= wait_cnt_q + 1'b1;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pp_host_ctrl.sv
module pp_host_ctrl
    import pp_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic              bus_done,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] pd_out,
    input  logic [BYTE_W-1:0] pd_in,
    output logic              pd_dir_in,
    output logic [3:0]        ctl_line_n,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val,
    output logic              irq,
    output logic              epp_req,
    output logic              epp_wr,
    output logic              epp_is_addr,
    output logic [BYTE_W-1:0] epp_wdata,
    input  logic              epp_ack,
    input  logic [BYTE_W-1:0] epp_rdata
);

    logic  wr_acc, rd_acc;
    logic  data_we, ctrl_we, stat_we, stat_re;
    logic  epp_go;
    ctrl_t ctrl_q;
    stat_t stat_q;
    byte_t dout_q, din_q;
    byte_t reg_mux;
    logic  reg_done_q;
    byte_t reg_rdata_q;
    logic  eng_done, eng_tmo;
    byte_t eng_rdata;

    assign wr_acc  = bus_req && bus_we;
    assign rd_acc  = bus_req && !bus_we;
    assign data_we = wr_acc && (bus_addr == OFS_DATA);
    assign ctrl_we = wr_acc && (bus_addr == OFS_CTRL);
    assign stat_we = wr_acc && (bus_addr == OFS_STAT);
    assign stat_re = rd_acc && (bus_addr == OFS_STAT);
    assign epp_go  = bus_req && is_epp_ofs(bus_addr) && epp_allowed(ctrl_q, !bus_we);

    pp_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .data_we (data_we),
        .ctrl_we (ctrl_we),
        .wdata   (bus_wdata),
        .pd_in   (pd_in),
        .ctrl_q  (ctrl_q),
        .dout_q  (dout_q),
        .din_q   (din_q)
    );

    pp_printer_model u_prn (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .stat_we    (stat_we),
        .stat_re    (stat_re),
        .tmo_set    (eng_tmo),
        .wdata      (bus_wdata),
        .ctrl_q     (ctrl_q),
        .dout_q     (dout_q),
        .stat_q     (stat_q),
        .irq_q      (irq),
        .byte_stb_q (byte_stb),
        .byte_val_q (byte_val)
    );

    pp_epp_engine #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .start       (epp_go),
        .start_wr    (bus_we),
        .start_addr  (bus_addr == OFS_EPP_ADDR),
        .start_wdata (bus_wdata),
        .epp_ack     (epp_ack),
        .epp_rdata   (epp_rdata),
        .epp_req     (epp_req),
        .epp_wr      (epp_wr),
        .epp_is_addr (epp_is_addr),
        .epp_wdata   (epp_wdata),
        .done_q      (eng_done),
        .rdata_q     (eng_rdata),
        .tmo_q       (eng_tmo)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_DATA:     reg_mux = ctrl_q.dir_in ? din_q : dout_q;
            OFS_STAT:     reg_mux = stat_q;
            OFS_CTRL:     reg_mux = ctrl_q;
            OFS_EPP_ADDR,
            OFS_EPP_DATA: reg_mux = EPP_IDLE_RD;
            default:      reg_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_done_q  <= 1'b0;
            reg_rdata_q <= '0;
        end else begin
            reg_done_q  <= bus_req && !epp_go;
            reg_rdata_q <= rd_acc ? reg_mux : '0;
        end
    end

    assign bus_done   = reg_done_q || eng_done;
    assign bus_rdata  = eng_done ? eng_rdata : reg_rdata_q;
    assign pd_out     = dout_q;
    assign pd_dir_in  = ctrl_q.dir_in;
    assign ctl_line_n = ~{ctrl_q.sel, ctrl_q.init, ctrl_q.alf, ctrl_q.stb};

endmodule

// File: rtl/pp_host_ctrl_chk.sv
module pp_host_ctrl_chk
    import pp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_done,
    input logic              pd_dir_in,
    input logic [3:0]        ctl_line_n,
    input logic              byte_stb,
    input logic              irq,
    input logic              epp_req,
    input logic              irq_en,
    input logic              stat_nbusy
);

    logic epp_ofs;
    logic lines_ok;
    assign epp_ofs  = (bus_addr == OFS_EPP_ADDR) || (bus_addr == OFS_EPP_DATA);
    assign lines_ok = (ctl_line_n == 4'b1011);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctl_line_n == 4'b0011) && !irq && !pd_dir_in);

    assert_stb_single_R5: assert property (@(posedge clk) disable iff (rst)
        byte_stb |=> !byte_stb);

    assert_stb_busy_R5: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> !stat_nbusy);

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en);

    assert_epp_wr_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && epp_ofs && !(lines_ok && !pd_dir_in)) |=> !epp_req);

    assert_epp_rd_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && epp_ofs && !(lines_ok && pd_dir_in)) |=> !epp_req);

    assert_epp_done_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(epp_req) |-> bus_done);

endmodule

bind pp_host_ctrl pp_host_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_done   (bus_done),
    .pd_dir_in  (pd_dir_in),
    .ctl_line_n (ctl_line_n),
    .byte_stb   (byte_stb),
    .irq        (irq),
    .epp_req    (epp_req),
    .irq_en     (ctrl_q.irq_en),
    .stat_nbusy (stat_q.nbusy)
);

// File: tb/pp_host_ctrl_tb.sv
`timescale 1ns/1ps
module pp_host_ctrl_tb;

    localparam int TMO = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_req = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_done;
    logic [7:0] bus_rdata, pd_out, byte_val, epp_wdata;
    logic [7:0] pd_in = 8'h3C;
    logic       pd_dir_in, byte_stb, irq, epp_req, epp_wr, epp_is_addr;
    logic [3:0] ctl_line_n;
    logic       epp_ack = 1'b0;
    logic [7:0] epp_rdata = '0;

    always #2.5 clk = ~clk;

    pp_host_ctrl #(.TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
        .bus_rdata(bus_rdata), .pd_out(pd_out), .pd_in(pd_in),
        .pd_dir_in(pd_dir_in), .ctl_line_n(ctl_line_n), .byte_stb(byte_stb),
        .byte_val(byte_val), .irq(irq), .epp_req(epp_req), .epp_wr(epp_wr),
        .epp_is_addr(epp_is_addr), .epp_wdata(epp_wdata), .epp_ack(epp_ack),
        .epp_rdata(epp_rdata)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard: expected completions, in order
    logic [8:0] q_exp[$];
    string      q_tag[$];

    always @(negedge clk) begin
        logic [8:0] e;
        string      t;
        if (!rst && bus_done) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R12 unexpected done", 1, 0);
            end else begin
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (e[8]) check(bus_rdata == e[7:0], t, bus_rdata, e[7:0]);
            end
        end
    end

    // printer sink observer
    int         stb_cnt = 0;
    logic [7:0] stb_last = '0;
    always @(negedge clk) begin
        if (!rst && byte_stb) begin
            stb_cnt++;
            stb_last = byte_val;
        end
    end

    // peripheral model
    bit         sink_on = 1'b1;
    logic [7:0] sink_val = '0;
    int         sink_cnt = 0;
    int         epp_starts = 0;
    logic       req_prev = 1'b0;
    logic       seen_wr = 1'b0, seen_addr = 1'b0;
    logic [7:0] seen_wdata = '0;
    always @(negedge clk) begin
        if (rst) begin
            epp_ack  = 1'b0;
            sink_cnt = 0;
        end else if (epp_ack) begin
            epp_ack  = 1'b0;
            sink_cnt = 0;
        end else if (epp_req && sink_on) begin
            sink_cnt++;
            if (sink_cnt == 2) begin
                epp_ack    = 1'b1;
                epp_rdata  = sink_val;
                seen_wr    = epp_wr;
                seen_addr  = epp_is_addr;
                seen_wdata = epp_wdata;
            end
        end
        if (epp_req && !req_prev) epp_starts++;
        req_prev = epp_req;
    end

    int lat;

    task automatic access(input bit we, input logic [2:0] a, input logic [7:0] wd,
                          input bit chk, input logic [7:0] exp, input string tag);
        q_exp.push_back({chk, exp});
        q_tag.push_back(tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        lat = 1;
        while (!bus_done) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        access(1'b1, a, d, 1'b0, 8'h00, "write");
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        access(1'b0, a, 8'h00, 1'b1, exp, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(ctl_line_n == 4'b0011, "R1 ctl_line_n", ctl_line_n, 4'b0011);
        check(irq == 1'b0, "R1 irq", irq, 0);
        rd(1, 8'hD9, "R1 status reset");
        rd(2, 8'h0C, "R1 control reset");
        rd(0, 8'h00, "R1 data reset");
        check(lat == 1, "R12 register latency", lat, 1);

        // R2 output latch
        wr(0, 8'hA5);
        check(pd_out == 8'hA5, "R2 pd_out", pd_out, 8'hA5);
        rd(0, 8'hA5, "R2 data out read");

        // R5 strobe edge
        wr(2, 8'h0D);
        check(stb_cnt == 1, "R5 byte pulse count", stb_cnt, 1);
        check(stb_last == 8'hA5, "R5 byte value", stb_last, 8'hA5);
        check(ctl_line_n == 4'b0010, "R3 lines strobe", ctl_line_n, 4'b0010);
        rd(1, 8'h59, "R5 busy set");
        rd(1, 8'h59, "R6 hold while strobe high");
        wr(2, 8'h0D);
        check(stb_cnt == 1, "R5 no pulse on repeat", stb_cnt, 1);

        // R6/R7 acknowledge walk with interrupt enabled
        wr(2, 8'h1C);
        rd(1, 8'h59, "R6 read before ack drop");
        check(irq == 1'b1, "R7 irq on ack drop", irq, 1);
        rd(1, 8'h19, "R6 ack cleared");
        check(irq == 1'b0, "R7 irq cleared by read", irq, 0);
        rd(1, 8'hD9, "R6 ready again");

        // R7 cleared by control write
        wr(2, 8'h1D);
        check(stb_cnt == 2, "R5 second pulse", stb_cnt, 2);
        wr(2, 8'h1C);
        rd(1, 8'h59, "R6 second walk");
        check(irq == 1'b1, "R7 irq again", irq, 1);
        wr(2, 8'h0C);
        check(irq == 1'b0, "R7 irq cleared by enable off", irq, 0);

        // R4 initialize
        wr(2, 8'h08);
        rd(1, 8'hD8, "R4 init status");
        rd(2, 8'h08, "R3 control readback");

        // R3 / R2 direction and input latch
        wr(2, 8'hEA);
        check(pd_dir_in == 1'b1, "R3 dir out", pd_dir_in, 1);
        check(ctl_line_n == 4'b0101, "R3 lines", ctl_line_n, 4'b0101);
        rd(2, 8'h2A, "R3 upper bits zero");
        rd(0, 8'h3C, "R2 input latch read");
        check(pd_out == 8'hA5, "R2 pd_out kept", pd_out, 8'hA5);

        // R13 unused offsets
        wr(5, 8'h77);
        rd(5, 8'h00, "R13 unused read");
        rd(2, 8'h2A, "R13 control untouched");

        // R8 write gating
        wr(4, 8'h11);
        check(epp_starts == 0, "R8 dropped write", epp_starts, 0);
        check(lat == 1, "R12 dropped latency", lat, 1);
        wr(2, 8'h14);
        wr(4, 8'h11);
        check(epp_starts == 1, "R8 data write started", epp_starts, 1);
        check(seen_wr == 1'b1 && seen_addr == 1'b0 && seen_wdata == 8'h11,
              "R8 data write fields", {seen_wr, seen_addr, seen_wdata}, 10'h211);
        wr(3, 8'h22);
        check(seen_addr == 1'b1 && seen_wdata == 8'h22,
              "R8 address write fields", {seen_addr, seen_wdata}, 9'h122);

        // R9 read gating
        rd(4, 8'hFF, "R9 dropped read");
        check(epp_starts == 2, "R9 no cycle", epp_starts, 2);
        wr(2, 8'h24);
        sink_val = 8'h9B;
        rd(4, 8'h9B, "R9 data read");
        check(seen_wr == 1'b0 && seen_addr == 1'b0, "R9 data read fields",
              {seen_wr, seen_addr}, 0);
        sink_val = 8'h4E;
        rd(3, 8'h4E, "R9 address read");
        check(seen_addr == 1'b1, "R9 address flag", seen_addr, 1);

        // R10 timeout
        sink_on = 1'b0;
        rd(4, 8'hFF, "R10 timeout data");
        check(lat == TMO + 1, "R12 timeout latency", lat, TMO + 1);
        rd(1, 8'hD9, "R10 timeout flag");
        sink_on = 1'b1;
        sink_val = 8'h01;
        rd(4, 8'h01, "R10 read after timeout");
        rd(1, 8'hD9, "R10 flag sticky");

        // R11 clear by writing 1
        wr(1, 8'h00);
        rd(1, 8'hD9, "R11 write zero keeps flag");
        wr(1, 8'h01);
        rd(1, 8'hD8, "R11 write one clears flag only");

        check(q_exp.size() == 0, "R12 all completions seen", q_exp.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule